// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns 32-bit device virtual addresses into physical addresses. It reads one 32-bit entry from a flat table in memory for each request. The table has one entry per 4 KB page, and the page number indexes it directly. An entry carries the physical page frame in its upper 20 bits and a valid flag in bit 0. An entry with the flag clear is treated as unmapped.

Software first programs the table base, then turns translation on by writing 3 to the enable field. With translation off, each request comes back unchanged. Only the lower 2 GB of the virtual space can be translated. A request above that limit faults at once and causes no memory read. A walk that finds an unmapped entry also faults. It records the memory address of the bad entry, so software can recover the page as (address − base) / 4, and it sets a sticky status bit.

Only one walk runs at a time. The request port stays busy from acceptance until the response.

Top module: `pt_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and all four registers read 0.
- R2: The enable register (offset 0x0) keeps the low 2 bits of the written value and reads them back. Translation is on only when the field equals 3.
- R3: With translation off, an accepted request responds in the next cycle with `rsp_paddr` equal to the request address and `rsp_fault` 0. It issues no memory read.
- R4: With translation on and an address below 0x8000_0000, the block issues exactly one memory read, at (base with bits 1:0 cleared) + (vaddr >> 12) × 4. The base register (offset 0x4) reads back with bits 1:0 cleared.
- R5: If the fetched entry has bit 0 set, the response is `{entry[31:12], vaddr[11:0]}` with `rsp_fault` 0.
- R6: If the fetched entry has bit 0 clear, the response has `rsp_fault` 1 and `rsp_paddr` 0. The entry's memory address is latched into the fault-address register (offset 0x8), and status bit 1 (offset 0xC) becomes 1.
- R7: With translation on, a request at or above 0x8000_0000 responds in the next cycle with `rsp_fault` 1 and `rsp_paddr` 0. It issues no memory read and leaves the status and fault-address registers unchanged.
- R8: `req_ready` stays 0 from the cycle after acceptance of a walking request until its response. A memory read request holds its address stable until `mem_req_ready`.
- R9: Writing offset 0xC with bit 1 set clears status bit 1, and writing it with bit 1 clear leaves the bit alone. A fault in the same cycle as a clear leaves the bit set.
- R10: The fault-address register holds the entry address of the most recent entry fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Response is a fault |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 32 | Entry data |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
A walk state that is stuck or stale shows up at the ports straight away. `req_ready` stays low, or a read goes out at an address other than base plus page times four. Either one appears in the first translation after the fault. A wrong offset capture or a wrong entry field choice corrupts `rsp_paddr` on the next valid walk. A broken range gate or enable gate shows as an unexpected memory read, or as a response that arrives late. A lost status or fault-address update appears when those registers are read back just after a fault response.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

   typedef enum logic [1:0] {
      WALK_IDLE = 2'd0,
      WALK_REQ  = 2'd1,
      WALK_WAIT = 2'd2
   } walk_state_e;

   localparam logic [3:0] OFS_ENABLE = 4'h0;
   localparam logic [3:0] OFS_BASE   = 4'h4;
   localparam logic [3:0] OFS_FADDR  = 4'h8;
   localparam logic [3:0] OFS_STATUS = 4'hC;

   localparam int STATUS_PTE_BIT = 1;
   localparam logic [1:0] ENABLE_ON = 2'b11;

endpackage

// File: rtl/pt_xlate_index.sv
module pt_xlate_index #(
   parameter int ADDR_W        = 32,
   parameter int PAGE_SHIFT    = 12,
   parameter int VA_LIMIT_LOG2 = 31
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] entry_addr,
   output logic              out_of_range
);
   localparam int ENTRY_SHIFT = $clog2(ADDR_W / 8);
   localparam int VPN_W       = ADDR_W - PAGE_SHIFT;

   if (PAGE_SHIFT <= ENTRY_SHIFT || PAGE_SHIFT >= ADDR_W) begin : g_bad_page
      $error("pt_xlate_index: PAGE_SHIFT out of range");
   end
   if (VA_LIMIT_LOG2 <= PAGE_SHIFT || VA_LIMIT_LOG2 > ADDR_W) begin : g_bad_limit
      $error("pt_xlate_index: VA_LIMIT_LOG2 out of range");
   end

   logic [ADDR_W-1:0] base_aligned;
   logic [ADDR_W-1:0] vpn_ext;

   always_comb begin
      base_aligned = base;
      base_aligned[ENTRY_SHIFT-1:0] = '0;
      vpn_ext = {{PAGE_SHIFT{1'b0}}, vaddr[ADDR_W-1:PAGE_SHIFT]};
      entry_addr = base_aligned + (vpn_ext << ENTRY_SHIFT);
   end

   if (VA_LIMIT_LOG2 == ADDR_W) begin : g_full_range
      assign out_of_range = 1'b0;
   end else begin : g_limited_range
      assign out_of_range = |vaddr[ADDR_W-1:VA_LIMIT_LOG2];
   end

   logic unused_vpn_w;
   assign unused_vpn_w = (VPN_W > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/pt_xlate_regs.sv
module pt_xlate_regs
   import pt_xlate_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int REG_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              pte_fault,
   input  logic [ADDR_W-1:0] pte_fault_addr,
   output logic              xlate_en,
   output logic [ADDR_W-1:0] table_base
);
   localparam int ALIGN_BITS = $clog2(ADDR_W / 8);

   if (REG_AW != 4) begin : g_bad_regaw
      $error("pt_xlate_regs: REG_AW must be 4");
   end

   logic [1:0]        enable_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] faddr_q;
   logic              pte_sticky_q;
   logic              wr_enable, wr_base, wr_status;

   assign wr_enable = reg_wr_en && (reg_addr == OFS_ENABLE);
   assign wr_base   = reg_wr_en && (reg_addr == OFS_BASE);
   assign wr_status = reg_wr_en && (reg_addr == OFS_STATUS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q     <= '0;
         base_q       <= '0;
         faddr_q      <= '0;
         pte_sticky_q <= 1'b0;
      end else begin
         if (wr_enable) enable_q <= reg_wdata[1:0];
         if (wr_base) begin
            base_q <= {reg_wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
         end
         if (pte_fault) begin
            faddr_q      <= pte_fault_addr;
            pte_sticky_q <= 1'b1;
         end else if (wr_status && reg_wdata[STATUS_PTE_BIT]) begin
            pte_sticky_q <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFS_ENABLE: reg_rdata[1:0] = enable_q;
         OFS_BASE:   reg_rdata = base_q;
         OFS_FADDR:  reg_rdata = faddr_q;
         OFS_STATUS: reg_rdata[STATUS_PTE_BIT] = pte_sticky_q;
         default:    reg_rdata = '0;
      endcase
   end

   assign xlate_en   = (enable_q == ENABLE_ON);
   assign table_base = base_q;

   a_r6_status_set: assert property (@(posedge clk) disable iff (!rst_n)
      pte_fault |=> pte_sticky_q && (faddr_q == $past(pte_fault_addr)));

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && reg_wdata[STATUS_PTE_BIT] && !pte_fault) |=> !pte_sticky_q);

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pte_fault && !(wr_status && reg_wdata[STATUS_PTE_BIT])) |=> $stable(pte_sticky_q));
endmodule

// File: rtl/pt_xlate_walker.sv
module pt_xlate_walker
   import pt_xlate_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xlate_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic [ADDR_W-1:0] entry_addr,
   input  logic              out_of_range,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              rsp_fault,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_data,
   output logic              pte_fault,
   output logic [ADDR_W-1:0] pte_fault_addr
);
   walk_state_e           state_q;
   logic [ADDR_W-1:0]     walk_addr_q;
   logic [PAGE_SHIFT-1:0] offset_q;
   logic                  rsp_valid_q, rsp_fault_q;
   logic [ADDR_W-1:0]     rsp_paddr_q;
   logic                  accept, entry_back;

   assign req_ready  = (state_q == WALK_IDLE);
   assign accept     = req_valid && req_ready;
   assign entry_back = (state_q == WALK_WAIT) && mem_rsp_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= WALK_IDLE;
         walk_addr_q <= '0;
         offset_q    <= '0;
         rsp_valid_q <= 1'b0;
         rsp_fault_q <= 1'b0;
         rsp_paddr_q <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         unique case (state_q)
            WALK_IDLE: if (accept) begin
               if (!xlate_en) begin
                  rsp_valid_q <= 1'b1;
                  rsp_fault_q <= 1'b0;
                  rsp_paddr_q <= req_vaddr;
               end else if (out_of_range) begin
                  rsp_valid_q <= 1'b1;
                  rsp_fault_q <= 1'b1;
                  rsp_paddr_q <= '0;
               end else begin
                  walk_addr_q <= entry_addr;
                  offset_q    <= req_vaddr[PAGE_SHIFT-1:0];
                  state_q     <= WALK_REQ;
               end
            end
            WALK_REQ: if (mem_req_ready) state_q <= WALK_WAIT;
            WALK_WAIT: if (mem_rsp_valid) begin
               rsp_valid_q <= 1'b1;
               state_q     <= WALK_IDLE;
               if (mem_rsp_data[0]) begin
                  rsp_fault_q <= 1'b0;
                  rsp_paddr_q <= {mem_rsp_data[ADDR_W-1:PAGE_SHIFT], offset_q};
               end else begin
                  rsp_fault_q <= 1'b1;
                  rsp_paddr_q <= '0;
               end
            end
            default: state_q <= WALK_IDLE;
         endcase
      end
   end

   assign rsp_valid      = rsp_valid_q;
   assign rsp_fault      = rsp_fault_q;
   assign rsp_paddr      = rsp_paddr_q;
   assign mem_req_valid  = (state_q == WALK_REQ);
   assign mem_req_addr   = walk_addr_q;
   assign pte_fault      = entry_back && !mem_rsp_data[0];
   assign pte_fault_addr = walk_addr_q;

   a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));

   a_r8_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(accept) || $past(mem_rsp_valid)));

   a_r7_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && xlate_en && out_of_range) |=> !mem_req_valid && rsp_valid && rsp_fault);

   a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
   parameter int ADDR_W        = 32,
   parameter int PAGE_SHIFT    = 12,
   parameter int VA_LIMIT_LOG2 = 31,
   parameter int REG_AW        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_vaddr,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              rsp_fault,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [ADDR_W-1:0] mem_rsp_data,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata
);
   logic              xlate_en;
   logic [ADDR_W-1:0] table_base;
   logic [ADDR_W-1:0] entry_addr;
   logic              out_of_range;
   logic              pte_fault;
   logic [ADDR_W-1:0] pte_fault_addr;

   pt_xlate_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .pte_fault(pte_fault), .pte_fault_addr(pte_fault_addr),
      .xlate_en(xlate_en), .table_base(table_base)
   );

   pt_xlate_index #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
                    .VA_LIMIT_LOG2(VA_LIMIT_LOG2)) u_index (
      .vaddr(req_vaddr), .base(table_base),
      .entry_addr(entry_addr), .out_of_range(out_of_range)
   );

   pt_xlate_walker #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_walker (
      .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .entry_addr(entry_addr), .out_of_range(out_of_range),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data),
      .pte_fault(pte_fault), .pte_fault_addr(pte_fault_addr)
   );

   a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !xlate_en) |=>
         rsp_valid && !rsp_fault && (rsp_paddr == $past(req_vaddr)));

   a_r1_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req_valid);
endmodule

// File: tb/tb_pt_xlate.sv
`timescale 1ns/1ps
module tb_pt_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        reg_wr_en = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #5 clk = ~clk;

   pt_xlate dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data),
      .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   // bench model of table contents: entries whose address bits 4:2 equal 5 are unmapped
   function automatic logic [31:0] entry_of(input logic [31:0] a);
      if (a[4:2] == 3'd5) return 32'h0;
      return {a[21:2] ^ 20'h5A3C7, 11'h0, 1'b1};
   endfunction

   function automatic logic [31:0] exp_entry_addr(input logic [31:0] b, input logic [31:0] va);
      return {b[31:2], 2'b00} + ({12'h0, va[31:12]} << 2);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model
   int          mem_reads = 0;
   logic [31:0] last_mem_addr = '0;
   bit          pend = 0;
   logic [31:0] pend_addr = '0;
   int          lat = 0;
   bit          clr_on_rsp = 0;
   bit          clr_pulse = 0;

   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      if (clr_pulse) begin
         reg_wr_en = 1'b0;
         clr_pulse = 0;
      end
      if (!rst_n) begin
         pend = 0;
         mem_req_ready = 1'b0;
      end else begin
         if (pend) begin
            if (lat == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = entry_of(pend_addr);
               pend = 0;
               if (clr_on_rsp) begin
                  reg_wr_en = 1'b1;
                  reg_addr  = 4'hC;
                  reg_wdata = 32'h2;
                  clr_pulse = 1;
                  clr_on_rsp = 0;
               end
            end else lat--;
         end
         mem_req_ready = ($urandom % 4) != 0;
         if (!pend && mem_req_valid && mem_req_ready) begin
            pend = 1;
            pend_addr = mem_req_addr;
            last_mem_addr = mem_req_addr;
            lat = $urandom % 3;
            mem_reads++;
         end
      end
   end

   // bench-side expected register state
   bit          m_en = 0;
   logic [31:0] m_base = '0;
   logic [31:0] m_faddr = '0;
   bit          m_stat = 0;

   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
      if (a == 4'h0) m_en = (d[1:0] == 2'b11);
      if (a == 4'h4) m_base = {d[31:2], 2'b00};
      if (a == 4'hC && d[1]) m_stat = 0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic check_fault_regs(input string req);
      logic [31:0] d;
      reg_read(4'h8, d);
      chk(d == m_faddr, req, d, m_faddr);
      reg_read(4'hC, d);
      chk(d == {30'h0, m_stat, 1'b0}, req, d, {30'h0, m_stat, 1'b0});
   endtask

   task automatic xlate(input logic [31:0] va);
      int reads0;
      int cyc;
      bit busy_ok;
      logic [31:0] ea, e;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      reads0 = mem_reads;
      req_valid = 1'b1; req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 0;
      busy_ok = 1;
      while (!rsp_valid && cyc < 60) begin
         if (req_ready) busy_ok = 0;
         @(negedge clk);
         cyc++;
      end
      chk(rsp_valid, "R8 response arrives", {31'h0, rsp_valid}, 32'h1);
      chk(busy_ok, "R8 ready low during walk", {31'h0, busy_ok}, 32'h1);
      if (!m_en) begin
         chk(!rsp_fault && rsp_paddr == va && cyc == 0, "R3 passthrough", rsp_paddr, va);
         chk(mem_reads == reads0, "R3 no memory read", mem_reads, reads0);
      end else if (va[31]) begin
         chk(rsp_fault && rsp_paddr == 0 && cyc == 0, "R7 range fault", rsp_paddr, 32'h0);
         chk(mem_reads == reads0, "R7 no memory read", mem_reads, reads0);
      end else begin
         ea = exp_entry_addr(m_base, va);
         e  = entry_of(ea);
         chk(mem_reads == reads0 + 1, "R4 one read", mem_reads, reads0 + 1);
         chk(last_mem_addr == ea, "R4 entry address", last_mem_addr, ea);
         if (e[0]) begin
            chk(!rsp_fault && rsp_paddr == {e[31:12], va[11:0]}, "R5 translated",
                rsp_paddr, {e[31:12], va[11:0]});
         end else begin
            chk(rsp_fault && rsp_paddr == 0, "R6 entry fault", rsp_paddr, 32'h0);
            m_faddr = ea;
            m_stat  = 1;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R8 run did not finish actual=%h expected=%h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd1234));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
          {req_ready, rsp_valid, mem_req_valid}, 3'b100);
      for (int i = 0; i < 4; i++) begin
         reg_read(4'(i * 4), d);
         chk(d == 0, "R1 register reset", d, 32'h0);
      end

      // R3 disabled passthrough
      xlate(32'h1234_5678);
      xlate(32'hFFFF_F001);

      // R4 base alignment
      reg_write(4'h4, 32'h1000_0003);
      reg_read(4'h4, d);
      chk(d == 32'h1000_0000, "R4 base readback", d, 32'h1000_0000);

      // R2 enable field
      reg_write(4'h0, 32'h1);
      reg_read(4'h0, d);
      chk(d == 32'h1, "R2 enable readback", d, 32'h1);
      xlate(32'h0000_4321);
      reg_write(4'h0, 32'h7);
      reg_read(4'h0, d);
      chk(d == 32'h3, "R2 enable field width", d, 32'h3);

      // R5 valid walk, R7 range edge cases
      xlate(32'h1234_4678);
      xlate(32'h7FFF_FFFF);
      xlate(32'h8000_0000);
      check_fault_regs("R7 registers untouched");

      // R6 / R10 entry faults
      xlate(32'h0000_5ABC);
      check_fault_regs("R6 fault capture");
      xlate(32'h0001_D000);
      check_fault_regs("R10 latest fault address");

      // R9 clear behaviour
      reg_write(4'hC, 32'h0);
      check_fault_regs("R9 write zero keeps");
      reg_write(4'hC, 32'h2);
      check_fault_regs("R9 write one clears");
      clr_on_rsp = 1;
      xlate(32'h0000_5000);
      check_fault_regs("R9 fault wins over clear");

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] va;
         if (i % 40 == 0) begin
            reg_write(4'h4, $urandom);
            reg_write(4'h0, (($urandom % 4) == 0) ? 32'h1 : 32'h3);
         end
         va = $urandom;
         if (($urandom % 8) != 0) va[31] = 1'b0;
         xlate(va);
         if (i % 50 == 0) check_fault_regs("R6 R10 random fault registers");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule